// File: doc/BRIEF.md
# Time-Multiplexed Round-Robin Online Checker

This block watches a group of identical functional sub-blocks while they run, using one shared checker instead of one checker per sub-block. A scheduler grants the checker to one sub-block at a time for a programmable number of cycles (the dwell), then moves to the next enabled sub-block in ascending cyclic order. During its slot, the selected sub-block's input and output buses are tapped. A duplicate of the sub-block's function recomputes the result from the tapped inputs, and the checker compares that result with the live output. Every connection to the sub-blocks is an input of this block, so the functional datapath is never stalled, back-pressured or modified.

Each monitored sub-block computes `y = rotl1(x) + x` (modulo 2^W) on a W-bit word, with a valid bit. Its output appears LAT = 2 clock cycles after its input. Two check modes are provided. In duplicate mode (`mode` = 0), both data and valid timing are compared. In assertion mode (`mode` = 1), only the valid-timing property is evaluated on the selected sub-block.

On the first mismatch, a sticky error flag is raised, and the failing index and a timestamp are captured. A saturating per-sub-block counter records how many slots actually performed comparisons, which serves as a coverage measure.

The scheduler is a three-state machine:
- `ST_IDLE`: not checking.
- `ST_SETTLE`: the first LAT cycles of a slot, while the duplicate pipeline fills with the new sub-block's data.
- `ST_CHECK`: comparing.

Its transitions are:
- START: `ST_IDLE` to `ST_SETTLE`, when `en` is high and the mask is non-zero.
- SETTLED: `ST_SETTLE` to `ST_CHECK`, after LAT slot cycles.
- ROTATE: from either active state to `ST_SETTLE` with a new index, when the dwell expires.
- STOP: from either active state to `ST_IDLE`, when `en` drops or the mask becomes zero.

Top module: `rr_online_checker`

## Requirements
- R1: After reset, `err_flag` = 0, `err_time` = 0, `checking` = 0, all `slot_cnt` fields = 0, and `cur_idx` = N-1 (3 with the default N = 4).
- R2: Once started, `cur_idx` holds each index for exactly `dwell` cycles and then moves to the next enabled index in ascending cyclic order. After reset, the first slot goes to the lowest enabled index.
- R3: An index whose `mask` bit is 0 is never selected. With `en` = 0, or with `mask` = 0, the scheduler goes idle (`checking` = 0) at the next edge and `cur_idx` stops changing.
- R4: A `dwell` value of 0 behaves as 1: the index advances on every cycle.
- R5: No comparison takes place in the first LAT = 2 cycles of a slot. `checking` is 1 only in slot cycles 2 to dwell-1, so a dwell of 2 or less never compares.
- R6: In duplicate mode (`mode` = 0), a mismatch is flagged when the live valid differs from the recomputed valid, or when the recomputed valid is 1 and the data differ from `rotl1(x) + x` of the input seen two cycles earlier.
- R7: In assertion mode (`mode` = 1), only the valid bits are compared, and data differences are ignored.
- R8: `err_flag` rises on the edge after the first mismatch cycle and stays high until `err_clr`. `err_idx` takes the index being checked in the mismatch cycle. `err_time` takes the number of clock edges since reset release at that cycle. Later mismatches do not overwrite either field, and rotation continues after an error.
- R9: `slot_cnt` field i (bits i*CNT_W upward) increments at the end of every slot of index i whose last cycle was a comparing cycle, and it saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables the rotation |
| mode | input | 1 | 0 = duplicate compare, 1 = valid-timing assertion only |
| mask | input | N | Per-sub-block enable for the rotation |
| dwell | input | DW_W | Cycles per slot (0 is treated as 1) |
| err_clr | input | 1 | Clears the sticky error flag |
| sub_in_dat | input | N*W | Tapped input data of every sub-block, index i at bits i*W |
| sub_in_vld | input | N | Tapped input valid of every sub-block |
| sub_out_dat | input | N*W | Tapped output data of every sub-block |
| sub_out_vld | input | N | Tapped output valid of every sub-block |
| cur_idx | output | IDX_W | Index currently granted the checker |
| checking | output | 1 | Comparisons active in this cycle |
| err_flag | output | 1 | Sticky error flag |
| err_idx | output | IDX_W | Index of the first failing sub-block |
| err_time | output | TS_W | Timestamp of the first mismatch cycle |
| slot_cnt | output | N*CNT_W | Saturating count of completed check slots per sub-block |

## Verification
- `cur_idx` changes on the edge that ends the dwell. For a slot starting on edge e, `checking` is therefore high after edges e+2 through e+dwell-1.
- A mismatch seen in slot cycle c shows up in `err_flag` one edge later. `err_time` equals the bench's own edge count at the mismatch cycle.
- Each slot counter moves on the edge that ends its slot.
- The bench counts rising edges from a known start and samples every output on the following falling edge, so each expected value is read in the exact cycle the requirement places it.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CHECK  = 2'd2
    } rrc_state_t;

endpackage

// File: rtl/rrc_sched.sv
module rrc_sched
    import rrc_pkg::*;
#(
    parameter int N     = 4,
    parameter int DW_W  = 16,
    parameter int LAT   = 2,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [N-1:0]     mask,
    input  logic [DW_W-1:0]  dwell,
    output logic [IDX_W-1:0] sel,
    output logic             chk_en,
    output logic             slot_done
);

    localparam logic [DW_W-1:0] SETTLE_LAST = DW_W'(LAT - 1);
    localparam logic [DW_W-1:0] ONE         = DW_W'(1);

    rrc_state_t       state, state_d;
    logic [IDX_W-1:0] sel_d, nxt_idx;
    logic [DW_W-1:0]  cnt, cnt_d, dw_eff;
    logic             go, slot_last;

    always_comb begin
        go        = en && (|mask);
        dw_eff    = (dwell == '0) ? ONE : dwell;
        slot_last = (cnt >= dw_eff - ONE);
    end

    // next enabled index after sel, ascending and cyclic; sel itself only if alone
    always_comb begin
        nxt_idx = sel;
        for (int i = N; i >= 1; i--) begin
            if (mask[(int'(sel) + i) % N]) nxt_idx = IDX_W'((int'(sel) + i) % N);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state;
        sel_d   = sel;
        cnt_d   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    state_d = ST_SETTLE;
                    sel_d   = nxt_idx;
                    cnt_d   = '0;
                end
            end
            ST_SETTLE, ST_CHECK: begin
                if (!go) begin
                    state_d = ST_IDLE;
                end else if (slot_last) begin
                    state_d = ST_SETTLE;
                    sel_d   = nxt_idx;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt + ONE;
                    if (state == ST_SETTLE && cnt >= SETTLE_LAST) state_d = ST_CHECK;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= IDX_W'(N - 1);
            cnt   <= '0;
        end else begin
            state <= state_d;
            sel   <= sel_d;
            cnt   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        chk_en    = (state == ST_CHECK);
        slot_done = (state == ST_CHECK) && slot_last;
    end

    // R2
    rotate_to_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE && sel != $past(sel))
            |-> (|($past(mask) & (N'(1) << sel))));

    // R5
    switch_not_compared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> !chk_en);

endmodule

// File: rtl/rrc_tap.sv
module rrc_tap #(
    parameter int N     = 4,
    parameter int W     = 8,
    parameter int LAT   = 2,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sel,
    input  logic [N*W-1:0]   sub_in_dat,
    input  logic [N-1:0]     sub_in_vld,
    input  logic [N*W-1:0]   sub_out_dat,
    input  logic [N-1:0]     sub_out_vld,
    output logic [W-1:0]     dup_dat,
    output logic             dup_vld,
    output logic [W-1:0]     live_dat,
    output logic             live_vld
);

    // replica of the monitored function
    function automatic logic [W-1:0] mix(input logic [W-1:0] x);
        return {x[W-2:0], x[W-1]} + x;
    endfunction

    logic [W-1:0] tap_dat;
    logic         tap_vld;
    logic [W-1:0] p_dat [LAT];
    logic [LAT-1:0] p_vld;

    always_comb begin
        tap_dat  = sub_in_dat[int'(sel)*W +: W];
        tap_vld  = sub_in_vld[sel];
        live_dat = sub_out_dat[int'(sel)*W +: W];
        live_vld = sub_out_vld[sel];
    end

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    p_dat[s] <= '0;
                    p_vld[s] <= 1'b0;
                end else begin
                    p_dat[s] <= mix(tap_dat);
                    p_vld[s] <= tap_vld;
                end
            end
        end else begin : g_delay
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    p_dat[s] <= '0;
                    p_vld[s] <= 1'b0;
                end else begin
                    p_dat[s] <= p_dat[s-1];
                    p_vld[s] <= p_vld[s-1];
                end
            end
        end
    end

    always_comb begin
        dup_dat = p_dat[LAT-1];
        dup_vld = p_vld[LAT-1];
    end

endmodule

// File: rtl/rrc_cmp.sv
module rrc_cmp #(
    parameter int W     = 8,
    parameter int IDX_W = 2,
    parameter int TS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic             mode,
    input  logic             err_clr,
    input  logic [IDX_W-1:0] sel,
    input  logic [W-1:0]     dup_dat,
    input  logic             dup_vld,
    input  logic [W-1:0]     live_dat,
    input  logic             live_vld,
    output logic             err_flag,
    output logic [IDX_W-1:0] err_idx,
    output logic [TS_W-1:0]  err_time
);

    logic [TS_W-1:0] ts;
    logic            vld_bad, dat_bad, hit;

    always_comb begin
        vld_bad = (dup_vld != live_vld);
        dat_bad = !mode && dup_vld && (dup_dat != live_dat);
        hit     = chk_en && (vld_bad || dat_bad);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts <= '0;
        else        ts <= ts + TS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_idx  <= '0;
            err_time <= '0;
        end else if (hit && !err_flag) begin
            err_flag <= 1'b1;
            err_idx  <= sel;
            err_time <= ts;
        end else if (err_clr) begin
            err_flag <= 1'b0;
        end
    end

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    // R8
    err_record_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && $past(err_flag)) |-> ($stable(err_idx) && $stable(err_time)));

endmodule

// File: rtl/rrc_cov.sv
module rrc_cov #(
    parameter int N     = 4,
    parameter int CNT_W = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_done,
    input  logic [IDX_W-1:0] sel,
    output logic [N*CNT_W-1:0] slot_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [N];

    for (genvar i = 0; i < N; i++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[i] <= '0;
            end else if (slot_done && sel == IDX_W'(i) && cnt_q[i] != CNT_MAX) begin
                cnt_q[i] <= cnt_q[i] + CNT_W'(1);
            end
        end

        always_comb slot_cnt[i*CNT_W +: CNT_W] = cnt_q[i];

        // R9
        cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[i] >= $past(cnt_q[i]));
    end

endmodule

// File: rtl/rr_online_checker.sv
module rr_online_checker #(
    parameter int N     = 4,
    parameter int W     = 8,
    parameter int LAT   = 2,
    parameter int DW_W  = 16,
    parameter int CNT_W = 16,
    parameter int TS_W  = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               mode,
    input  logic [N-1:0]       mask,
    input  logic [DW_W-1:0]    dwell,
    input  logic               err_clr,
    input  logic [N*W-1:0]     sub_in_dat,
    input  logic [N-1:0]       sub_in_vld,
    input  logic [N*W-1:0]     sub_out_dat,
    input  logic [N-1:0]       sub_out_vld,
    output logic [IDX_W-1:0]   cur_idx,
    output logic               checking,
    output logic               err_flag,
    output logic [IDX_W-1:0]   err_idx,
    output logic [TS_W-1:0]    err_time,
    output logic [N*CNT_W-1:0] slot_cnt
);

    logic [IDX_W-1:0] sel;
    logic             chk_en, slot_done;
    logic [W-1:0]     dup_dat, live_dat;
    logic             dup_vld, live_vld;

    rrc_sched #(.N(N), .DW_W(DW_W), .LAT(LAT), .IDX_W(IDX_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .en(en), .mask(mask), .dwell(dwell),
        .sel(sel), .chk_en(chk_en), .slot_done(slot_done)
    );

    rrc_tap #(.N(N), .W(W), .LAT(LAT), .IDX_W(IDX_W)) u_tap (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .sub_in_dat(sub_in_dat), .sub_in_vld(sub_in_vld),
        .sub_out_dat(sub_out_dat), .sub_out_vld(sub_out_vld),
        .dup_dat(dup_dat), .dup_vld(dup_vld),
        .live_dat(live_dat), .live_vld(live_vld)
    );

    rrc_cmp #(.W(W), .IDX_W(IDX_W), .TS_W(TS_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .mode(mode),
        .err_clr(err_clr), .sel(sel),
        .dup_dat(dup_dat), .dup_vld(dup_vld),
        .live_dat(live_dat), .live_vld(live_vld),
        .err_flag(err_flag), .err_idx(err_idx), .err_time(err_time)
    );

    rrc_cov #(.N(N), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cov (
        .clk(clk), .rst_n(rst_n), .slot_done(slot_done), .sel(sel),
        .slot_cnt(slot_cnt)
    );

    always_comb begin
        cur_idx  = sel;
        checking = chk_en;
    end

    // R3
    idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || mask == '0) |=> !checking);

endmodule

// File: tb/rr_online_checker_test.sv
module rr_online_checker_test;

    localparam int N = 4;
    localparam int W = 8;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             en = 1'b0, mode = 1'b0, err_clr = 1'b0;
    logic [N-1:0]     mask = '0;
    logic [15:0]      dwell = '0;
    logic [N*W-1:0]   sub_in_dat, sub_out_dat;
    logic [N-1:0]     sub_in_vld, sub_out_vld;
    logic [1:0]       cur_idx, err_idx;
    logic             checking, err_flag;
    logic [31:0]      err_time;
    logic [N*CNT_W-1:0] slot_cnt;

    rr_online_checker #(.N(N), .W(W), .LAT(2), .DW_W(16), .CNT_W(CNT_W), .TS_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .mask(mask), .dwell(dwell),
        .err_clr(err_clr), .sub_in_dat(sub_in_dat), .sub_in_vld(sub_in_vld),
        .sub_out_dat(sub_out_dat), .sub_out_vld(sub_out_vld),
        .cur_idx(cur_idx), .checking(checking), .err_flag(err_flag),
        .err_idx(err_idx), .err_time(err_time), .slot_cnt(slot_cnt)
    );

    // environment: four monitored sub-blocks, y = rotl1(x) + x, two-cycle latency
    logic [1:0]  fkind = 2'd0;   // 0 none, 1 data bit 4 flipped, 2 valid stuck low
    logic [1:0]  fblk = 2'd0;
    logic        vld_all = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  in_d [N];
    logic [7:0]  s1d [N];
    logic [7:0]  s2d [N];
    logic [N-1:0] in_v = '0, s1v = '0, s2v = '0;
    longint cyc = 0;

    function automatic logic [7:0] bmix(input logic [7:0] x);
        return {x[6:0], x[7]} + x;
    endfunction

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        for (int k = 0; k < N; k++) begin
            in_d[k] <= lfsr[7:0] ^ 8'(k * 37);
            in_v[k] <= vld_all | lfsr[k + 8] | lfsr[k + 12];
            s1d[k]  <= bmix(in_d[k]);
            s2d[k]  <= s1d[k];
        end
        s1v <= in_v;
        s2v <= s1v;
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always_comb begin
        for (int k = 0; k < N; k++) begin
            sub_in_dat[k*W +: W]  = in_d[k];
            sub_out_dat[k*W +: W] = s2d[k] ^ ((fkind == 2'd1 && fblk == 2'(k)) ? 8'h10 : 8'h00);
            sub_out_vld[k]        = s2v[k] & ~(fkind == 2'd2 && fblk == 2'(k));
        end
        sub_in_vld = in_v;
    end

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; err_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // {mode, mask[3:0], dwell[7:0], fblk[1:0], fkind[1:0], exp_err, exp_idx[1:0]}
    localparam logic [19:0] VEC [9] = '{
        {1'b0, 4'hF, 8'd6, 2'd0, 2'd0, 1'b0, 2'd0},  // R6 healthy blocks, no false alarm
        {1'b0, 4'hF, 8'd6, 2'd2, 2'd1, 1'b1, 2'd2},  // R6 data fault on 2
        {1'b0, 4'hB, 8'd6, 2'd2, 2'd1, 1'b0, 2'd0},  // R3 faulty block 2 masked out
        {1'b0, 4'hF, 8'd2, 2'd1, 2'd1, 1'b0, 2'd0},  // R5 dwell 2 never compares
        {1'b0, 4'hF, 8'd3, 2'd3, 2'd1, 1'b1, 2'd3},  // R5 dwell 3 one compare per slot
        {1'b1, 4'hF, 8'd6, 2'd0, 2'd1, 1'b0, 2'd0},  // R7 data fault ignored
        {1'b1, 4'hF, 8'd6, 2'd1, 2'd2, 1'b1, 2'd1},  // R7 valid fault found
        {1'b0, 4'hF, 8'd6, 2'd3, 2'd2, 1'b1, 2'd3},  // R6 valid fault in duplicate mode
        {1'b0, 4'h0, 8'd6, 2'd0, 2'd1, 1'b0, 2'd0}   // R3 empty mask stays idle
    };

    initial begin
        longint m0;

        do_reset();
        // R1 reset state
        chk("R1", "err_flag", err_flag, 0);
        chk("R1", "checking", checking, 0);
        chk("R1", "cur_idx", cur_idx, 3);
        chk("R1", "slot_cnt", slot_cnt, 0);
        chk("R1", "err_time", err_time, 0);

        // table walk
        for (int r = 0; r < 9; r++) begin
            do_reset();
            mode  = VEC[r][19];
            mask  = VEC[r][18:15];
            dwell = {8'd0, VEC[r][14:7]};
            fblk  = VEC[r][6:5];
            fkind = VEC[r][4:3];
            vld_all = 1'b0;
            en = 1'b1;
            tick(400);
            chk(r == 2 || r == 8 ? "R3" : (r == 3 || r == 4 ? "R5" : (r == 5 || r == 6 ? "R7" : "R6")),
                $sformatf("row %0d err_flag", r), err_flag, VEC[r][2]);
            if (VEC[r][2]) chk("R8", $sformatf("row %0d err_idx", r), err_idx, VEC[r][1:0]);
        end
        fkind = 2'd0;

        // R2 rotation with dwell 4
        do_reset();
        mode = 1'b0; mask = 4'hF; dwell = 16'd4; en = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            tick(1);
            chk("R2", $sformatf("cur_idx edge %0d", k), cur_idx, ((k - 1) / 4) % 4);
            chk("R5", $sformatf("checking edge %0d", k), checking, ((k - 1) % 4) >= 2);
        end

        // R3 masked indices skipped
        do_reset();
        mask = 4'b1010; dwell = 16'd3; en = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            tick(1);
            chk("R3", $sformatf("mask skip edge %0d", k), cur_idx, (((k - 1) / 3) % 2 == 0) ? 1 : 3);
        end

        // R4 dwell 0 acts as 1
        do_reset();
        mask = 4'hF; dwell = 16'd0; en = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            tick(1);
            chk("R4", $sformatf("dwell0 edge %0d", k), cur_idx, (k - 1) % 4);
        end
        chk("R4", "dwell0 checking", checking, 0);

        // R3 enable drop goes idle and freezes index
        do_reset();
        mask = 4'hF; dwell = 16'd8; en = 1'b1;
        tick(4);
        chk("R5", "checking in slot cycle 3", checking, 1);
        en = 1'b0;
        tick(1);
        chk("R3", "checking after en low", checking, 0);
        tick(10);
        chk("R3", "cur_idx frozen", cur_idx, 0);

        // R8 error record timing
        do_reset();
        vld_all = 1'b1; fkind = 2'd1; fblk = 2'd0;
        mask = 4'b0011; dwell = 16'd8; mode = 1'b0;
        m0 = cyc;
        en = 1'b1;
        tick(3);
        chk("R8", "err_flag before latch", err_flag, 0);
        tick(1);
        chk("R8", "err_flag set", err_flag, 1);
        chk("R8", "err_idx", err_idx, 0);
        chk("R8", "err_time", err_time, m0 + 3);
        tick(10);
        chk("R8", "rotation continues", cur_idx, 1);
        chk("R8", "err_time kept", err_time, m0 + 3);
        chk("R8", "err_flag held", err_flag, 1);
        err_clr = 1'b1;
        tick(1);
        err_clr = 1'b0;
        chk("R8", "err_flag cleared", err_flag, 0);
        fkind = 2'd0; vld_all = 1'b0;

        // R9 slot counters
        do_reset();
        mask = 4'b0001; dwell = 16'd4; en = 1'b1;
        tick(13);
        chk("R9", "slot_cnt[0] after 3 slots", slot_cnt[3:0], 3);
        chk("R9", "other counters", slot_cnt[15:4], 0);
        tick(80);
        chk("R9", "slot_cnt[0] saturated", slot_cnt[3:0], 15);

        // R9 with R5: slots without compares are not counted
        do_reset();
        mask = 4'b0001; dwell = 16'd2; en = 1'b1;
        tick(40);
        chk("R9", "dwell 2 slot_cnt[0]", slot_cnt[3:0], 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL all watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule